// File: doc/BRIEF.md
# Chipset Control Register Bank

This block is a memory-mapped set of 32-bit control words that a system controller exposes to the processor. A single request port carries a valid strobe, a write flag, a 14-bit byte offset, an access size and write data. Byte, halfword and word accesses are all accepted. Decoding always works on the containing word. A narrow read returns the selected lane, shifted down and zero-extended. A narrow write merges its lane into the current word before the word is stored.

The bank holds these registers:
- a configuration word,
- the base and limit of a DMA translation table,
- a row of fifteen remote speed words,
- thirty-two DMA channel words (eight channels of four),
- a small group of fixed or lightly writable words.

It also holds an I/O cache byte-mask word with unusual semantics. Writes are ORed into it. A read that finds it all ones clears it afterwards.

Offsets that decode to none of these registers read as zero and drop writes. Read data is registered and appears one cycle after the request, together with a response strobe.

Top module: `chipset_regbank`

## Requirements
- R1: After reset the words read as follows:
  - configuration (offset 0x000) = 0x00000104,
  - translation base (0x018) and limit (0x020) = 0,
  - each speed word = 7,
  - each DMA channel word = 0,
  - byte mask (0x058) = 0,
  - offset 0x208 = 0,
  - offset 0x210 = 0x00018186,
  - offsets 0x220 and 0x238 = 7.
- R2: A read request accepted at a clock edge sets `rsp_valid` and drives `rsp_rdata` during the following cycle. In a cycle after any edge without a read request, `rsp_valid` is 0 and `rsp_rdata` is 0.
- R3: Decoding ignores `req_addr[1:0]`. A word access (`req_size` 2 or 3) with nonzero low offset bits reads or writes the containing aligned word.
- R4: The configuration, translation base and translation limit words are fully read/write. Each keeps its value unless it is written.
- R5: Speed word i sits at offset 0x070 + 8*i, for i from 0 to 14, and is read/write. The word offsets 0x074, 0x07C and so on, which fall between them, are unmapped.
- R6: DMA channel c, register r (c 0..7, r 0..3) sits at offset 0x100 + 32*c + 8*r and is read/write. The word offsets 0x104, 0x10C and so on, which fall between them, are unmapped.
- R7: Reads use `req_size` 0 for a byte, 1 for a halfword, and 2 or 3 for a word.
  - A byte read returns bits [8*a+7:8*a] of the word, where a = `req_addr[1:0]`, in `rsp_rdata[7:0]`.
  - A halfword read returns the upper half when `req_addr[1]` is 1 and the lower half otherwise, in `rsp_rdata[15:0]`.
  - All higher bits of `rsp_rdata` are zero.
- R8: A byte write replaces only the lane selected by `req_addr[1:0]` with `req_wdata[7:0]`. A halfword write replaces only the half selected by `req_addr[1]` with `req_wdata[15:0]`. The other bits of the word are unchanged.
- R9: A write of any size to the byte-mask word (0x058) ORs the merged word into the stored value, so no bit that is set is ever cleared by a write.
- R10: A read of any size of the byte-mask word returns its current value. If that value is all ones, the word is zero from the next cycle on. Otherwise it is unchanged.
- R11: Writes to offsets 0x208, 0x220 and 0x238 have no effect. Offset 0x210 is read/write.
- R12: An offset that maps to no register reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset within the bank |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, lane aligned to bit 0 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data, zero when not valid |

## Verification
A write lands on the clock edge that accepts it, so a read issued in the very next cycle already observes it. Read data and its strobe become visible in the cycle after that read's edge, and the self-clearing of the byte mask takes effect on the same edge. The bench therefore drives each request at a falling edge and lets one rising edge pass. It then samples `rsp_rdata` and `rsp_valid` at the next falling edge, and it checks the zero-after-idle rule one falling edge later. Every "no effect" case is confirmed by reading back the words the access could have disturbed.

// File: rtl/chipset_regbank.sv
module chipset_regbank #(
  parameter int          ADDR_W    = 14,
  parameter int          N_SPEED   = 15,
  parameter int          N_CHAN    = 8,
  parameter int          CH_REGS   = 4,
  parameter logic [31:0] CFG_RST   = 32'h0000_0104,
  parameter logic [31:0] SPEED_RST = 32'd7,
  parameter logic [31:0] AUX_RST   = 32'h0001_8186,
  parameter logic [31:0] LOCK_VAL  = 32'd7,
  parameter logic [31:0] TAIL_VAL  = 32'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int DMA_N  = N_CHAN * CH_REGS;
  localparam int SPD_IW = (N_SPEED > 1) ? $clog2(N_SPEED) : 1;
  localparam int DMA_IW = (DMA_N > 1) ? $clog2(DMA_N) : 1;

  localparam logic [ADDR_W-1:0] OFF_CFG   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFF_TBASE = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] OFF_TLIM  = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'('h058);
  localparam logic [ADDR_W-1:0] OFF_SPD   = ADDR_W'('h070);
  localparam logic [ADDR_W-1:0] SPD_END   = ADDR_W'('h070 + 8 * N_SPEED);
  localparam logic [ADDR_W-1:0] OFF_DMA   = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] DMA_END   = ADDR_W'('h100 + 8 * DMA_N);
  localparam logic [ADDR_W-1:0] OFF_ZERO  = ADDR_W'('h208);
  localparam logic [ADDR_W-1:0] OFF_AUX   = ADDR_W'('h210);
  localparam logic [ADDR_W-1:0] OFF_LOCK  = ADDR_W'('h220);
  localparam logic [ADDR_W-1:0] OFF_TAIL  = ADDR_W'('h238);

  logic [31:0] cfg_q, tbase_q, tlim_q, mask_q, aux_q;
  logic [31:0] speed_q [N_SPEED];
  logic [31:0] dma_q   [DMA_N];

  wire rd_go = req_valid && !req_write;
  wire wr_go = req_valid && req_write;

  wire [ADDR_W-1:0] aoff     = {req_addr[ADDR_W-1:2], 2'b00};
  wire [ADDR_W-1:0] spd_diff = aoff - OFF_SPD;
  wire [ADDR_W-1:0] dma_diff = aoff - OFF_DMA;
  wire [SPD_IW-1:0] spd_idx  = spd_diff[3 +: SPD_IW];
  wire [DMA_IW-1:0] dma_idx  = dma_diff[3 +: DMA_IW];
  wire spd_hit = (aoff >= OFF_SPD) && (aoff < SPD_END) && !aoff[2];
  wire dma_hit = (aoff >= OFF_DMA) && (aoff < DMA_END) && !aoff[2];

  logic        hit;
  logic [31:0] cur;
  always_comb begin
    hit = 1'b1;
    cur = '0;
    if (spd_hit)      cur = speed_q[spd_idx];
    else if (dma_hit) cur = dma_q[dma_idx];
    else begin
      case (aoff)
        OFF_CFG:   cur = cfg_q;
        OFF_TBASE: cur = tbase_q;
        OFF_TLIM:  cur = tlim_q;
        OFF_MASK:  cur = mask_q;
        OFF_ZERO:  cur = '0;
        OFF_AUX:   cur = aux_q;
        OFF_LOCK:  cur = LOCK_VAL;
        OFF_TAIL:  cur = TAIL_VAL;
        default:   hit = 1'b0;
      endcase
    end
  end

  logic [4:0]  sh;
  logic [31:0] lmask;
  always_comb begin
    case (req_size)
      2'd0:    begin sh = {req_addr[1:0], 3'b000}; lmask = 32'h0000_00FF; end
      2'd1:    begin sh = {req_addr[1], 4'b0000};  lmask = 32'h0000_FFFF; end
      default: begin sh = 5'd0;                    lmask = 32'hFFFF_FFFF; end
    endcase
  end

  wire [31:0] wr_word = (cur & ~(lmask << sh)) | ((req_wdata & lmask) << sh);
  wire [31:0] rd_lane = (cur >> sh) & lmask;

  wire mask_sel = (aoff == OFF_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RST;
      tbase_q   <= '0;
      tlim_q    <= '0;
      aux_q     <= AUX_RST;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_go && aoff == OFF_CFG)   cfg_q   <= wr_word;
      if (wr_go && aoff == OFF_TBASE) tbase_q <= wr_word;
      if (wr_go && aoff == OFF_TLIM)  tlim_q  <= wr_word;
      if (wr_go && aoff == OFF_AUX)   aux_q   <= wr_word;
      if (wr_go && mask_sel)                   mask_q <= mask_q | wr_word;
      else if (rd_go && mask_sel && &mask_q)   mask_q <= '0;
      rsp_valid <= rd_go;
      rsp_rdata <= rd_go ? rd_lane : '0;
    end
  end

  for (genvar g = 0; g < N_SPEED; g++) begin : g_speed
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        speed_q[g] <= SPEED_RST;
      else if (wr_go && spd_hit && spd_idx == SPD_IW'(g)) speed_q[g] <= wr_word;
    end
  end

  for (genvar g = 0; g < DMA_N; g++) begin : g_dma
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        dma_q[g] <= '0;
      else if (wr_go && dma_hit && dma_idx == DMA_IW'(g)) dma_q[g] <= wr_word;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> (!rsp_valid && rsp_rdata == '0));
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && aoff == OFF_CFG) |=> $stable(cfg_q));
  // R9
  mask_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && mask_sel) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
  // R10
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && mask_sel && &mask_q) |=> (mask_q == '0));
  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !hit) |=> (rsp_rdata == '0));

endmodule

// File: tb/chipset_regbank_tb.sv
module chipset_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chipset_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    total++;
    if (rsp_valid !== 1'b1) begin
      bad++;
      $display("FAIL R2 rsp_valid actual=%0b expected=1 at addr %03h", rsp_valid, a);
    end
  endtask

  task automatic rdchk(input string tag, input logic [13:0] a, input logic [1:0] sz,
                       input logic [31:0] exp);
    logic [31:0] d;
    rd(a, sz, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk("R2 rsp_valid idle after reset", {31'd0, rsp_valid}, 32'd0);
    rdchk("R1 cfg", 14'h000, 2, 32'h0000_0104);
    rdchk("R1 tbase", 14'h018, 2, 32'h0);
    rdchk("R1 tlim", 14'h020, 2, 32'h0);
    rdchk("R1 speed0", 14'h070, 2, 32'd7);
    rdchk("R1 speed14", 14'h0E0, 2, 32'd7);
    rdchk("R1 dma first", 14'h100, 2, 32'h0);
    rdchk("R1 dma last", 14'h1F8, 2, 32'h0);
    rdchk("R1 mask", 14'h058, 2, 32'h0);
    rdchk("R1 0x208", 14'h208, 2, 32'h0);
    rdchk("R1 0x210", 14'h210, 2, 32'h0001_8186);
    rdchk("R1 0x220", 14'h220, 2, 32'd7);
    rdchk("R1 0x238", 14'h238, 2, 32'd7);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    rd(14'h210, 2, d);
    chk("R2 data one cycle later", d, 32'h0001_8186);
    @(negedge clk);
    chk("R2 valid drops when idle", {31'd0, rsp_valid}, 32'd0);
    chk("R2 data zero when idle", rsp_rdata, 32'd0);
  endtask

  task automatic t_rw;
    wr(14'h000, 2, 32'hDEAD_BEEF);
    rdchk("R4 cfg rw", 14'h000, 2, 32'hDEAD_BEEF);
    wr(14'h01B, 2, 32'h1234_5678);
    rdchk("R3 misaligned word write base", 14'h018, 2, 32'h1234_5678);
    rdchk("R3 misaligned word read base", 14'h01A, 3, 32'h1234_5678);
    wr(14'h020, 2, 32'h0FED_CBA9);
    rdchk("R4 tlim rw", 14'h020, 2, 32'h0FED_CBA9);
    rdchk("R4 cfg unchanged", 14'h000, 2, 32'hDEAD_BEEF);
  endtask

  task automatic t_speed;
    for (int i = 0; i < 15; i++) wr(14'(14'h070 + 8*i), 2, 32'h100 + i);
    for (int i = 0; i < 15; i++) rdchk("R5 speed readback", 14'(14'h070 + 8*i), 2, 32'h100 + i);
    wr(14'h074, 2, 32'hFFFF_FFFF);
    rdchk("R5 gap reads zero", 14'h074, 2, 32'h0);
    rdchk("R12 neighbour 0x070 kept", 14'h070, 2, 32'h100);
    rdchk("R12 neighbour 0x078 kept", 14'h078, 2, 32'h101);
  endtask

  task automatic t_dma;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++)
        wr(14'(14'h100 + 32*c + 8*r), 2, 32'hA000_0000 | (c << 8) | r);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++)
        rdchk("R6 dma readback", 14'(14'h100 + 32*c + 8*r), 2, 32'hA000_0000 | (c << 8) | r);
    wr(14'h104, 2, 32'h5555_5555);
    rdchk("R6 gap 0x104 zero", 14'h104, 2, 32'h0);
    rdchk("R6 0x100 kept", 14'h100, 2, 32'hA000_0000);
    rdchk("R6 0x108 kept", 14'h108, 2, 32'hA000_0001);
  endtask

  task automatic t_lanes;
    wr(14'h000, 2, 32'h1122_3344);
    rdchk("R7 byte0", 14'h000, 0, 32'h44);
    rdchk("R7 byte1", 14'h001, 0, 32'h33);
    rdchk("R7 byte2", 14'h002, 0, 32'h22);
    rdchk("R7 byte3", 14'h003, 0, 32'h11);
    rdchk("R7 half lo", 14'h000, 1, 32'h3344);
    rdchk("R7 half hi", 14'h002, 1, 32'h1122);
  endtask

  task automatic t_merge;
    wr(14'h000, 2, 32'h1122_3344);
    wr(14'h001, 0, 32'hFFFF_FFAB);
    rdchk("R8 byte merge", 14'h000, 2, 32'h1122_AB44);
    wr(14'h002, 1, 32'hFFFF_CAFE);
    rdchk("R8 half merge", 14'h000, 2, 32'hCAFE_AB44);
    wr(14'h0E3, 0, 32'h0000_0099);
    rdchk("R8 byte merge speed14", 14'h0E0, 2, 32'h9900_010E);
  endtask

  task automatic t_mask;
    wr(14'h058, 2, 32'h0000_000F);
    wr(14'h058, 2, 32'h0000_00F0);
    rdchk("R9 or accumulate", 14'h058, 2, 32'h0000_00FF);
    wr(14'h05B, 0, 32'h0000_0080);
    rdchk("R9 byte write ors lane", 14'h058, 2, 32'h8000_00FF);
    wr(14'h058, 2, 32'h0);
    rdchk("R10 not all ones stays", 14'h058, 2, 32'h8000_00FF);
    wr(14'h058, 2, 32'hFFFF_FFFF);
    rdchk("R10 all ones returned", 14'h058, 2, 32'hFFFF_FFFF);
    rdchk("R10 cleared after read", 14'h058, 2, 32'h0);
    wr(14'h058, 2, 32'hFFFF_FFFF);
    rdchk("R10 byte read all ones", 14'h059, 0, 32'hFF);
    rdchk("R10 cleared after byte read", 14'h058, 2, 32'h0);
  endtask

  task automatic t_ro;
    wr(14'h220, 2, 32'h0);
    wr(14'h238, 2, 32'hFFFF_FFFF);
    wr(14'h208, 2, 32'h1234_0000);
    rdchk("R11 0x220 ignores write", 14'h220, 2, 32'd7);
    rdchk("R11 0x238 ignores write", 14'h238, 2, 32'd7);
    rdchk("R11 0x208 ignores write", 14'h208, 2, 32'h0);
    wr(14'h210, 2, 32'h1234_5678);
    rdchk("R11 0x210 writable", 14'h210, 2, 32'h1234_5678);
  endtask

  task automatic t_unmapped;
    rdchk("R12 0x3FF0 zero", 14'h3FF0, 2, 32'h0);
    rdchk("R12 0x2F8 zero", 14'h2F8, 2, 32'h0);
    rdchk("R12 0x010 zero", 14'h010, 2, 32'h0);
    wr(14'h200, 2, 32'hFFFF_FFFF);
    wr(14'h3000, 2, 32'hFFFF_FFFF);
    rdchk("R12 0x200 still zero", 14'h200, 2, 32'h0);
    rdchk("R12 dma last kept", 14'h1F8, 2, 32'hA000_0703);
    rdchk("R12 cfg kept", 14'h000, 2, 32'hCAFE_AB44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_timing;
    t_rw;
    t_speed;
    t_dma;
    t_lanes;
    t_merge;
    t_mask;
    t_ro;
    t_unmapped;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule